// File: doc/BRIEF.md
# Segmented Multiplexed Bus Cycle Sequencer

This block carries out one memory or I/O transfer at a time for a 16-bit processor core. The core presents a segment value, an offset, a direction flag and, for writes, a data word. The block forms a 20-bit physical address by shifting the segment left four places and adding the offset. It then runs a fixed four-clock bus cycle on a shared set of address/data lines. The address goes out in the first clock. The lines then carry write data, or they are released so that the addressed device can drive read data.

The block provides an address-latch strobe so that external logic can capture the address before the lines change use. It also provides a direction strobe for the external transceivers. At the end of a read, the word on the lines is captured and returned to the core, and a one-cycle completion pulse follows every transfer. A request is taken only while the sequencer reports idle. The completion cycle already counts as idle, so transfers can follow each other with no gap.

Top module: `segbus_seq`

## Requirements
- R1: The physical address driven in T1 equals segment×16 + offset, computed on 20 bits (for example 1234h:0020h gives 12360h and 1005h:5555h gives 155A5h).
- R2: A carry out of bit 19 of the address sum is dropped, so FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R3: An accepted request produces exactly four bus clocks, T1, T2, T3 and T4. `req_ready` is low in all four and high again in the following cycle.
- R4: `ale` is high in T1 only, and in T1 `ad_oe` is high and `ad_o` carries the full 20-bit address.
- R5: In a write, `ad_oe` stays high in T2, T3 and T4, and `ad_o` holds the write data in bits 15:0 with bits 19:16 at zero.
- R6: In a read, `ad_oe` is low in T2, T3 and T4.
- R7: `rd_data` takes the value of `ad_i` present in the last clock of T4. Values on `ad_i` in T2 and T3 have no effect. A write leaves `rd_data` unchanged.
- R8: `done` is high for exactly one cycle, the cycle right after T4, and in that cycle the bus is released.
- R9: A request presented while the sequencer is busy is ignored: it does not change the current cycle's bus values and does not start a later cycle.
- R10: `xmit` is high from T1 through T4 of a write, and low during a read and while idle.
- R11: After reset the block is idle, with `ad_oe`, `ale`, `xmit` and `done` low and `rd_data` zero.
- R12: A request presented in the `done` cycle is accepted, and its T1 follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| ad_o | output | 20 | Shared line output value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 16 | Shared line input value (data bits) |
| ale | output | 1 | Address latch strobe |
| xmit | output | 1 | Transceiver direction, 1 = block transmits |

## Verification
The completion pulse of one transfer and the acceptance of the next request fall in the same cycle. The bench provokes this by raising a new request in exactly the cycle where `done` is high. It then checks both outcomes: the read data of the first transfer is correct, and the second transfer's T1 appears on the very next clock, with its address and `ale`. A companion test raises a request in mid-cycle with different data, and checks that neither the shared lines nor the later idle period are disturbed.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } bus_state_e;
endpackage

// File: rtl/segbus_addr.sv
module segbus_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] phys_q,
  output logic              write_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] off_w;
  logic [ADDR_W-1:0] sum_w;

  // Segment scaled by 16, offset zero-extended; the carry past the top bit is dropped.
  always_comb begin
    base_w = {seg_i, {SHIFT{1'b0}}};
    off_w  = ADDR_W'(off_i);
    sum_w  = base_w + off_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (load_en) begin
      phys_q  <= sum_w;
      write_q <= write_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/segbus_fsm.sv
module segbus_fsm
  import segbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       accept,
  output logic       idle,
  output bus_state_e state_q
);
  bus_state_e state_d;

  always_comb begin
    idle   = (state_q == ST_IDLE);
    accept = idle && req_valid;
    unique case (state_q)
      ST_IDLE: state_d = accept ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/segbus_pads.sv
module segbus_pads
  import segbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state_q,
  input  logic [ADDR_W-1:0] phys_q,
  input  logic              write_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              ale,
  output logic              xmit,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic cap_en;
  logic end_t4;

  always_comb begin
    ad_o  = '0;
    ad_oe = 1'b0;
    ale   = 1'b0;
    xmit  = 1'b0;
    unique case (state_q)
      ST_T1: begin
        ad_o  = phys_q;
        ad_oe = 1'b1;
        ale   = 1'b1;
        xmit  = write_q;
      end
      ST_T2, ST_T3, ST_T4: begin
        xmit  = write_q;
        ad_oe = write_q;
        if (write_q) ad_o = ADDR_W'(wdata_q);
      end
      default: ;
    endcase
  end

  always_comb begin
    end_t4 = (state_q == ST_T4);
    cap_en = end_t4 && !write_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= ad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= end_t4;
  end
endmodule

// File: rtl/segbus_seq.sv
module segbus_seq
  import segbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale,
  output logic              xmit
);
  logic              rst_meta, rst_sync_n;
  logic              accept;
  bus_state_e        state_q;
  logic [ADDR_W-1:0] phys_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  segbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .accept    (accept),
    .idle      (req_ready),
    .state_q   (state_q)
  );

  segbus_addr #(
    .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (accept),
    .seg_i   (req_seg),
    .off_i   (req_off),
    .write_i (req_write),
    .wdata_i (req_wdata),
    .phys_q  (phys_q),
    .write_q (write_q),
    .wdata_q (wdata_q)
  );

  segbus_pads #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) u_pads (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .state_q (state_q),
    .phys_q  (phys_q),
    .write_q (write_q),
    .wdata_q (wdata_q),
    .ad_i    (ad_i),
    .ad_o    (ad_o),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .xmit    (xmit),
    .rd_data (rd_data),
    .done    (done)
  );
endmodule

// File: rtl/segbus_seq_chk.sv
module segbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ale,
  input logic ad_oe,
  input logic xmit,
  input logic done
);
  // R4
  ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && !req_ready));

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && !req_ready));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !xmit) |=> !ad_oe);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !ad_oe && !ale));

  // R10
  xmit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !xmit);
endmodule

bind segbus_seq segbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ale       (ale),
  .ad_oe     (ad_oe),
  .xmit      (xmit),
  .done      (done)
);

// File: tb/segbus_seq_test.sv
module segbus_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, ad_oe, ale, xmit;
  logic [15:0] rd_data;
  logic [19:0] ad_o;
  logic [15:0] ad_i = '0;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  segbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ale(ale), .xmit(xmit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  task automatic issue(input bit wr, input logic [15:0] s, input logic [15:0] o,
                       input logic [15:0] wd);
    chk("R12 ready before request", {31'b0, req_ready}, 1);
    req_valid = 1'b1; req_write = wr; req_seg = s; req_off = o; req_wdata = wd;
  endtask

  // Walks T1..T4 and the done cycle; returns at the negedge of the done cycle.
  task automatic follow(input bit wr, input logic [19:0] exp_addr,
                        input logic [15:0] wd, input logic [15:0] rval,
                        input logic [15:0] prev_rd, input bit intrude);
    @(negedge clk); // T1
    chk("R1 address in T1", {12'b0, ad_o}, {12'b0, exp_addr});
    chk("R4 ale in T1", {31'b0, ale}, 1);
    chk("R4 oe in T1", {31'b0, ad_oe}, 1);
    chk("R3 busy in T1", {31'b0, req_ready}, 0);
    chk("R10 xmit in T1", {31'b0, xmit}, {31'b0, wr});
    req_valid = 1'b0;
    ad_i = ~rval;
    if (intrude) begin
      req_valid = 1'b1; req_seg = 16'hA5A5; req_off = 16'h0101;
      req_wdata = ~wd; req_write = ~wr;
    end
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk("R4 ale low after T1", {31'b0, ale}, 0);
      chk("R3 busy T2-T4", {31'b0, req_ready}, 0);
      chk("R10 xmit T2-T4", {31'b0, xmit}, {31'b0, wr});
      chk("R3 no done yet", {31'b0, done}, 0);
      if (wr) begin
        chk(intrude ? "R9 write data kept" : "R5 oe in data phase", {31'b0, ad_oe}, 1);
        chk(intrude ? "R9 write lines kept" : "R5 write lines", {12'b0, ad_o}, {16'b0, wd});
      end else begin
        chk("R6 lines released", {31'b0, ad_oe}, 0);
      end
      if (k == 3) ad_i = rval ^ 16'h00FF;
      if (k == 4) begin
        ad_i = rval;
        if (intrude) req_valid = 1'b0;
      end
    end
    @(negedge clk); // done cycle
    chk("R8 done after T4", {31'b0, done}, 1);
    chk("R8 bus released at done", {31'b0, ad_oe}, 0);
    chk("R3 idle after T4", {31'b0, req_ready}, 1);
    if (wr) chk("R7 write keeps rd_data", {16'b0, rd_data}, {16'b0, prev_rd});
    else    chk("R7 read sampled end of T4", {16'b0, rd_data}, {16'b0, rval});
    ad_i = 16'h0;
  endtask

  task automatic settle(input string tag);
    @(negedge clk);
    chk({tag, " done one cycle"}, {31'b0, done}, 0);
    chk({tag, " no new T1"}, {31'b0, ale}, 0);
    chk({tag, " idle"}, {31'b0, req_ready}, 1);
  endtask

  task automatic t_reset;
    chk("R11 ready", {31'b0, req_ready}, 1);
    chk("R11 oe", {31'b0, ad_oe}, 0);
    chk("R11 ale", {31'b0, ale}, 0);
    chk("R11 xmit", {31'b0, xmit}, 0);
    chk("R11 done", {31'b0, done}, 0);
    chk("R11 rd_data", {16'b0, rd_data}, 0);
  endtask

  task automatic t_read_basic;
    issue(1'b0, 16'h1234, 16'h0020, 16'h0);
    chk("R1 example one", {12'b0, phys(16'h1234, 16'h0020)}, 32'h12360);
    follow(1'b0, 20'h12360, 16'h0, 16'hBEEF, 16'h0, 1'b0);
    settle("R8");
  endtask

  task automatic t_write_basic;
    issue(1'b1, 16'h1005, 16'h5555, 16'hC3A7);
    follow(1'b1, 20'h155A5, 16'hC3A7, 16'h1111, 16'hBEEF, 1'b0);
    settle("R8");
  endtask

  task automatic t_wrap;
    issue(1'b0, 16'hFFFF, 16'h0010, 16'h0);
    follow(1'b0, 20'h00000, 16'h0, 16'h5A5A, 16'hBEEF, 1'b0);
    settle("R2");
    issue(1'b1, 16'hFFFF, 16'hFFFF, 16'h8001);
    follow(1'b1, 20'h0FFEF, 16'h8001, 16'h0, 16'h5A5A, 1'b0);
    settle("R2");
  endtask

  task automatic t_ignore;
    issue(1'b1, 16'h0400, 16'h0033, 16'h7E81);
    follow(1'b1, phys(16'h0400, 16'h0033), 16'h7E81, 16'h0, 16'h5A5A, 1'b1);
    settle("R9");
    settle("R9");
  endtask

  task automatic t_back_to_back;
    issue(1'b0, 16'h2000, 16'h0004, 16'h0);
    follow(1'b0, 20'h20004, 16'h0, 16'h0F0F, 16'h5A5A, 1'b0);
    issue(1'b0, 16'h3000, 16'hFFFE, 16'h0);
    follow(1'b0, 20'h3FFFE, 16'h0, 16'hF00D, 16'h0F0F, 1'b0);
    settle("R12");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_basic();
    t_wrap();
    t_ignore();
    t_back_to_back();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule